// File: doc/BRIEF.md
# Interrupt Concentrator with Mapping Registers

The concentrator watches 64 level-sensitive interrupt sources and hands at most one of them to the processor at a time. Sources 0 to 31 come from expansion slots. Sources 32 to 63 come from on-board devices. Each input is registered into a pending vector. A source can only be chosen if its mapping register has the enable bit set. Slot sources share one mapping register for each group of four. Each on-board source has a mapping register of its own.

Once a request is issued, it stays on the output until software retires it. Software retires it by writing a clear register, or by writing the owning mapping register with the enable bit at zero. In the same clock edge as the retirement, the block scans the pending sources again and picks the next one.

Software uses a simple 32-bit register port. Writes are strobes. Reads are combinational. The word on the port is already in bus order, so bit 31 is the most significant bit of the big-endian word. Only the upper word of each 8-byte register slot responds, which is the word with address bit 2 set.

Top module: `intConcentrator`

## Requirements
- R1: Each source input is sampled into a pending bit on every clock edge. A source that drops before it is chosen is never issued. Dropping a source whose request has already been issued does not withdraw that request.
- R2: A pending source can only be chosen when its mapping enable is set. Slot source n uses the enable of slot group n/4. On-board source 32+i uses the enable of on-board register i. All enables are zero after every reset.
- R3: Slot group g is mapped at address 0xC04+8g and reads {enable, 0x7C0 | (g<<2)} in bits 31 and 30:0. On-board register i is mapped at 0x1004+8i and reads {enable, 0x7E0+i}. A write changes only bit 31.
- R4: When no request is held, the block picks the lowest-numbered source that is both pending and enabled. All slot sources therefore come before any on-board source.
- R5: Only one request is outstanding at a time. reqValid and reqNum stay unchanged until a retiring write arrives. A newly pending source never preempts the current request, even if it has a lower number.
- R6: A write to the slot clear register at 0x1404+0x20g retires the request only when reqNum < 32 and reqNum/4 == g. Any other write there has no effect.
- R7: A write to the on-board clear register at 0x1804+8i retires the request only when reqNum == 32+i.
- R8: A mapping register write with bit 31 at zero retires the outstanding request if that request is governed by the register written.
- R9: On the clock edge that retires a request, the outputs already show the next choice made under R4, or reqValid is low if nothing is eligible. The source just retired is chosen again if it is still pending and enabled.
- R10: Words with address bit 2 clear, and all unmapped addresses, read as zero. Writes to them change nothing.
- R11: Assume no request is held and the source's enable is already set. When the source input rises before clock edge k, reqValid rises at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 64 | Level interrupt sources: bits 0-31 are slots, bits 32-63 are on-board devices |
| regWrEn | input | 1 | Register write strobe, active for one cycle per write |
| regAddr | input | 16 | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| reqValid | output | 1 | An interrupt request is outstanding |
| reqNum | output | 6 | Number of the outstanding interrupt |

## Verification
The assertions assume that regAddr and regWrEn are stable over each clock edge. They also assume that irqIn changes only between edges, so that the pending bit a request rose from can be traced back exactly two samples. The bench changes every input on the falling edge and pulses regWrEn for exactly one cycle. It deasserts a source only between register writes, so each retirement sees a well-defined pending set.

// File: rtl/intcPkg.sv
package intcPkg;
  localparam int IDX_W = 5;

  localparam logic [15:0] SLOT_MAP_BASE = 16'h0C00;
  localparam logic [15:0] SLOT_MAP_MASK = 16'hFFC0;
  localparam logic [15:0] OBD_MAP_BASE  = 16'h1000;
  localparam logic [15:0] OBD_CLR_BASE  = 16'h1800;
  localparam logic [15:0] SLOT_CLR_BASE = 16'h1400;
  localparam logic [15:0] PAGE_MASK     = 16'hFF00;

  localparam logic [30:0] MAP_PRESET = 31'h7C0;
  localparam logic [30:0] OBD_TAG    = 31'h020;

  typedef struct packed {
    logic             slotMapSel;
    logic             obdMapSel;
    logic             slotMapWr;
    logic             obdMapWr;
    logic             slotClr;
    logic             obdClr;
    logic             mapEn;
    logic [IDX_W-1:0] idx;
  } intcStrobe_t;
endpackage

// File: rtl/intcDecode.sv
module intcDecode
  import intcPkg::*;
(
  input  logic        regWrEn,
  input  logic [15:0] regAddr,
  input  logic [31:0] regWrData,
  output intcStrobe_t strb
);
  logic hiWord;
  logic slotMapHit, obdMapHit, slotClrHit, obdClrHit;

  always_comb begin
    hiWord     = regAddr[2];
    slotMapHit = hiWord && ((regAddr & SLOT_MAP_MASK) == SLOT_MAP_BASE);
    obdMapHit  = hiWord && ((regAddr & PAGE_MASK) == OBD_MAP_BASE);
    slotClrHit = hiWord && ((regAddr & PAGE_MASK) == SLOT_CLR_BASE);
    obdClrHit  = hiWord && ((regAddr & PAGE_MASK) == OBD_CLR_BASE);

    strb            = '0;
    strb.slotMapSel = slotMapHit;
    strb.obdMapSel  = obdMapHit;
    strb.slotMapWr  = regWrEn && slotMapHit;
    strb.obdMapWr   = regWrEn && obdMapHit;
    strb.slotClr    = regWrEn && slotClrHit;
    strb.obdClr     = regWrEn && obdClrHit;
    strb.mapEn      = regWrData[31];
    if (slotMapHit)      strb.idx = {2'b00, regAddr[5:3]};
    else if (slotClrHit) strb.idx = {2'b00, regAddr[7:5]};
    else                 strb.idx = regAddr[7:3];
  end
endmodule

// File: rtl/intcCore.sv
module intcCore
  import intcPkg::*;
#(
  parameter int NUM_SLOT = 32,
  parameter int NUM_OBD  = 32,
  parameter int GRP_SIZE = 4,
  localparam int NUM_SRC   = NUM_SLOT + NUM_OBD,
  localparam int NUM_W     = $clog2(NUM_SRC),
  localparam int NUM_GRP   = NUM_SLOT / GRP_SIZE,
  localparam int GRP_W     = $clog2(NUM_GRP),
  localparam int GRP_SHIFT = $clog2(GRP_SIZE),
  localparam int OBD_W     = $clog2(NUM_OBD)
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  intcStrobe_t        strb,
  output logic [31:0]        regRdData,
  output logic               reqValid,
  output logic [NUM_W-1:0]   reqNum
);
  logic [NUM_SRC-1:0] pendReg;
  logic [NUM_GRP-1:0] slotEn, slotEnNext;
  logic [NUM_OBD-1:0] obdEn, obdEnNext;
  logic [NUM_SRC-1:0] srcEn, eligible;
  logic [NUM_W-1:0]   pickNum;
  logic               reqIsSlot, grpMatch, obdMatch, retire;

  always_comb begin
    slotEnNext = slotEn;
    obdEnNext  = obdEn;
    if (strb.slotMapWr) slotEnNext[strb.idx[GRP_W-1:0]] = strb.mapEn;
    if (strb.obdMapWr)  obdEnNext[strb.idx[OBD_W-1:0]]  = strb.mapEn;
  end

  for (genvar i = 0; i < NUM_SLOT; i++) begin : g_slotEn
    assign srcEn[i] = slotEnNext[i / GRP_SIZE];
  end
  for (genvar j = 0; j < NUM_OBD; j++) begin : g_obdEn
    assign srcEn[NUM_SLOT + j] = obdEnNext[j];
  end

  assign eligible = pendReg & srcEn;

  always_comb begin
    pickNum = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (eligible[k]) pickNum = NUM_W'(k);
    end
  end

  always_comb begin
    reqIsSlot = reqNum < NUM_W'(NUM_SLOT);
    grpMatch  = reqIsSlot && (reqNum[GRP_SHIFT +: GRP_W] == strb.idx[GRP_W-1:0]);
    obdMatch  = !reqIsSlot && (reqNum[OBD_W-1:0] == strb.idx[OBD_W-1:0]);
    retire    = reqValid && (
                  (strb.slotClr && grpMatch) ||
                  (strb.obdClr && obdMatch) ||
                  (strb.slotMapWr && !strb.mapEn && grpMatch) ||
                  (strb.obdMapWr && !strb.mapEn && obdMatch));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendReg  <= '0;
      slotEn   <= '0;
      obdEn    <= '0;
      reqValid <= 1'b0;
      reqNum   <= '0;
    end else begin
      pendReg <= irqIn;
      slotEn  <= slotEnNext;
      obdEn   <= obdEnNext;
      if (!reqValid || retire) begin
        reqValid <= |eligible;
        reqNum   <= (|eligible) ? pickNum : reqNum;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (strb.slotMapSel)
      regRdData = {slotEn[strb.idx[GRP_W-1:0]],
                   MAP_PRESET | (31'(strb.idx[GRP_W-1:0]) << GRP_SHIFT)};
    else if (strb.obdMapSel)
      regRdData = {obdEn[strb.idx[OBD_W-1:0]],
                   (MAP_PRESET | OBD_TAG) + 31'(strb.idx[OBD_W-1:0])};
  end
endmodule

// File: rtl/intConcentrator.sv
module intConcentrator
  import intcPkg::*;
#(
  parameter int NUM_SLOT = 32,
  parameter int NUM_OBD  = 32,
  parameter int GRP_SIZE = 4,
  localparam int NUM_SRC = NUM_SLOT + NUM_OBD,
  localparam int NUM_W   = $clog2(NUM_SRC)
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               regWrEn,
  input  logic [15:0]        regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  output logic               reqValid,
  output logic [NUM_W-1:0]   reqNum
);
  intcStrobe_t strb;

  intcDecode u_decode (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strb      (strb)
  );

  intcCore #(
    .NUM_SLOT (NUM_SLOT),
    .NUM_OBD  (NUM_OBD),
    .GRP_SIZE (GRP_SIZE)
  ) u_core (
    .clk       (clk),
    .rstN      (rstN),
    .irqIn     (irqIn),
    .strb      (strb),
    .regRdData (regRdData),
    .reqValid  (reqValid),
    .reqNum    (reqNum)
  );
endmodule

// File: rtl/intcChecker.sv
module intcChecker (
  input logic        clk,
  input logic        rstN,
  input logic [63:0] irqIn,
  input logic        regWrEn,
  input logic [15:0] regAddr,
  input logic [31:0] regRdData,
  input logic        reqValid,
  input logic [5:0]  reqNum
);
  // R5: with no write, an outstanding request is held unchanged
  a_r5_hold_without_write: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !regWrEn) |=> (reqValid && $stable(reqNum)));

  // R1, R11: a fresh request comes from a source that was high two samples back
  a_r1_source_seen: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) |-> ((($past(irqIn, 2) >> reqNum) & 64'd1) == 64'd1));

  // R10: lower words always read zero
  a_r10_lower_word_zero: assert property (@(posedge clk) disable iff (!rstN)
    !regAddr[2] |-> (regRdData == 32'd0));

  // R3: slot mapping registers keep their preset low bits
  a_r3_slot_preset: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr[15:6] == 10'h030 && regAddr[2]) |->
      (regRdData[30:0] == (31'h7C0 | (31'(regAddr[5:3]) << 2))));

  // R3: on-board mapping registers keep their preset low bits
  a_r3_obd_preset: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr[15:8] == 8'h10 && regAddr[2]) |->
      (regRdData[30:0] == (31'h7E0 + 31'(regAddr[7:3]))));
endmodule

bind intConcentrator intcChecker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .irqIn     (irqIn),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regRdData (regRdData),
  .reqValid  (reqValid),
  .reqNum    (reqNum)
);

// File: tb/test_intConcentrator.sv
module test_intConcentrator;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] irqIn = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        reqValid;
  logic [5:0]  reqNum;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    bit          isRead;
    bit          expValid;
    logic [5:0]  expNum;
    logic [31:0] expData;
    string       tag;
  } item_t;

  item_t expQ[$];
  event  chkEv;

  always #(CLK_PERIOD/2) clk = ~clk;

  intConcentrator i_intConcentrator (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .reqValid(reqValid), .reqNum(reqNum)
  );

  // monitor: pops expected items and compares them against the outputs
  initial begin
    forever begin
      @(chkEv);
      while (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        checks++;
        if (it.isRead) begin
          if (regRdData !== it.expData) begin
            failures++;
            $display("FAIL %s: read 0x%04h got 0x%08h expected 0x%08h",
                     it.tag, regAddr, regRdData, it.expData);
          end
        end else if (reqValid !== it.expValid ||
                     (it.expValid && reqNum !== it.expNum)) begin
          failures++;
          $display("FAIL %s: req got %0b/%0d expected %0b/%0d",
                   it.tag, reqValid, reqNum, it.expValid, it.expNum);
        end
      end
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    step();
    regWrEn = 1'b0;
  endtask

  task automatic expReq(input bit v, input int n, input string tag);
    item_t it;
    it.isRead = 0; it.expValid = v; it.expNum = 6'(n); it.expData = '0; it.tag = tag;
    expQ.push_back(it);
    -> chkEv;
    #1;
  endtask

  task automatic expRd(input logic [15:0] a, input logic [31:0] d, input string tag);
    item_t it;
    regAddr = a;
    #1;
    it.isRead = 1; it.expValid = 0; it.expNum = '0; it.expData = d; it.tag = tag;
    expQ.push_back(it);
    -> chkEv;
    #1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    step();
    // reset state
    expReq(0, 0, "R5 reset idle");
    expRd(16'h0C1C, 32'h0000_07CC, "R3 slot group 3 preset");
    expRd(16'h102C, 32'h0000_07E5, "R3 onboard 5 preset");
    expRd(16'h0C18, 32'h0, "R10 lower word");
    expRd(16'h2000, 32'h0, "R10 unmapped read");

    // gating
    irqIn = 64'd1 << 5;
    step(3);
    expReq(0, 0, "R2 disabled source held back");
    wr(16'h0C0C, 32'h8000_0000);
    expReq(1, 5, "R2 group enable issues source 5");
    expRd(16'h0C0C, 32'h8000_07C4, "R3 enable readback");

    // no preemption
    irqIn = (64'd1 << 5) | (64'd1 << 4);
    step(3);
    expReq(1, 5, "R5 lower source does not preempt");
    wr(16'h1804, 32'h0);
    expReq(1, 5, "R7 unrelated onboard clear");
    wr(16'h1404, 32'h0);
    expReq(1, 5, "R6 other group clear");
    wr(16'h1424, 32'h0);
    expReq(1, 4, "R9 R6 clear picks lowest pending");

    // drop after issue
    irqIn = 64'd1 << 5;
    step(3);
    expReq(1, 4, "R1 drop does not withdraw");
    wr(16'h1424, 32'h0);
    expReq(1, 5, "R9 next after clear");

    // withdraw
    wr(16'h0C0C, 32'h0);
    expReq(0, 0, "R8 slot withdraw");
    expRd(16'h0C0C, 32'h0000_07C4, "R3 enable cleared");

    // scan order and onboard
    irqIn = '0;
    step();
    wr(16'h1014, 32'h8000_0000);
    wr(16'h103C, 32'h8000_0000);
    wr(16'h0C3C, 32'h8000_0000);
    irqIn = (64'd1 << 30) | (64'd1 << 34) | (64'd1 << 39);
    step();
    expReq(0, 0, "R11 not yet after one edge");
    step();
    expReq(1, 30, "R11 R4 slot before onboard");
    irqIn = (64'd1 << 34) | (64'd1 << 39);
    step();
    wr(16'h14E4, 32'h0);
    expReq(1, 34, "R4 lowest onboard next");
    wr(16'h183C, 32'h0);
    expReq(1, 34, "R7 wrong onboard index");
    wr(16'h1814, 32'h0);
    expReq(1, 34, "R9 R7 still pending reselected");
    irqIn = 64'd1 << 39;
    step();
    wr(16'h1814, 32'h0);
    expReq(1, 39, "R7 matching clear");
    wr(16'h103C, 32'h0);
    expReq(0, 0, "R8 onboard withdraw");

    // ignored writes
    wr(16'h2000, 32'hFFFF_FFFF);
    expRd(16'h2000, 32'h0, "R10 unmapped write ignored");
    wr(16'h0C08, 32'h8000_0000);
    expRd(16'h0C0C, 32'h0000_07C4, "R10 lower word write ignored");
    irqIn = 64'd1 << 5;
    step(3);
    expReq(0, 0, "R10 group stays disabled");
    wr(16'h0C0C, 32'hFFFF_FFFF);
    expReq(1, 5, "R2 enable via full write");
    expRd(16'h0C0C, 32'h8000_07C4, "R3 low bits not writable");

    // second reset
    rstN = 1'b0;
    #1;
    expReq(0, 0, "R5 reset clears request");
    step(2);
    rstN = 1'b1;
    expRd(16'h0C0C, 32'h0000_07C4, "R2 reset clears slot enable");
    expRd(16'h1014, 32'h0000_07E2, "R2 reset clears onboard enable");
    step(3);
    expReq(0, 0, "R2 pending but disabled after reset");

    step();
    summary();
  end
endmodule